// File: doc/BRIEF.md
# Activation Frame and Lane Allocator

This block keeps track of activation contexts inside one dataflow processing element. It owns a pool of physical frames, and each frame is divided into matching lanes. Every live activation ID is bound to exactly one (frame, lane) pair. One activation can open a frame alone. Further activations can join that frame on its spare lanes, so related activations share constants while keeping separate operand matching state.

Frame-control commands arrive one per cycle on a single command port. The response (accept or reject, the frame and lane concerned, whether the whole frame returned to the pool, and the clear pulses for the matching state and the frame slots) is combinational in the same cycle as the command. The state change is visible from the next cycle. A separate lookup port translates an activation ID into its frame and lane for the operand matcher. A configuration port preloads bindings while no command is being issued.

Top module: `frame_lane_alloc`

## Requirements
- R1: After reset no frame is in use, every lookup misses, and the first ALLOC is granted frame 0, lane 0.
- R2: Command codes on `cmd_op` are: 0 = ALLOC, 1 = FREE, 2 = ALLOC_SHARED, 3 = FREE_LANE. An ALLOC binds `cmd_id` to lane 0 of the lowest-numbered frame not in use, and marks that frame as in use.
- R3: An ALLOC is rejected, with no change of state, when every frame is in use or when `cmd_id` is already bound.
- R4: An ALLOC_SHARED binds `cmd_id` to the lowest-numbered free lane of the frame that holds `cmd_parent`.
- R5: An ALLOC_SHARED is rejected, with no change of state, when `cmd_parent` is not bound, when the parent's frame has no free lane, or when `cmd_id` is already bound.
- R6: A FREE of a bound ID whose frame still has other occupied lanes releases only that lane. It reports frame_freed = 0 and pulses `lane_clr`.
- R7: A FREE that releases the last occupied lane of its frame returns the frame to the pool. It reports frame_freed = 1 and pulses `slot_clr` together with `lane_clr`.
- R8: FREE_LANE releases the lane and pulses `lane_clr`, but it never returns the frame to the pool. frame_freed stays 0, and ALLOC keeps skipping that frame even when it has no occupied lane left.
- R9: A FREE or FREE_LANE of an ID that is not bound is rejected, and nothing changes.
- R10: The lookup port reports the frame and lane of a bound ID, with `lk_miss` = 0. For an unbound ID it raises `lk_miss`.
- R11: A configuration write binds `cfg_id` to (`cfg_frame`, `cfg_lane`) and marks that frame as in use, but only in a cycle with `cmd_valid` low. In a cycle with `cmd_valid` high it is ignored.
- R12: Each command is answered in the cycle it is presented, and its effect is visible to the lookup port and to commands from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A frame-control command is presented |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_id | input | 8 | Activation ID the command concerns |
| cmd_parent | input | 8 | Parent activation ID for ALLOC_SHARED |
| rsp_reject | output | 1 | Command refused |
| rsp_frame | output | 3 | Frame assigned or released |
| rsp_lane | output | 2 | Lane assigned or released |
| rsp_frame_freed | output | 1 | The physical frame returned to the pool |
| lane_clr | output | 1 | Pulse: clear matching state of rsp_frame/rsp_lane |
| slot_clr | output | 1 | Pulse: clear slot contents of rsp_frame |
| lk_id | input | 8 | Activation ID to translate |
| lk_miss | output | 1 | lk_id is not bound |
| lk_frame | output | 3 | Frame of lk_id |
| lk_lane | output | 2 | Lane of lk_id |
| cfg_we | input | 1 | Preload a binding |
| cfg_frame | input | 3 | Frame of the preloaded binding |
| cfg_lane | input | 2 | Lane of the preloaded binding |
| cfg_id | input | 8 | Activation ID of the preloaded binding |

## Verification
Allocation is tried in three patterns: fresh frames in sequence, a frame filled lane by lane until a shared request overflows it, and the pool drained until ALLOC is refused. Together they separate frame choice from lane choice and show that lowest-index selection holds. The release side is tried with FREE on a frame that still has other occupants, with FREE on the last occupant, and with FREE_LANE on the last occupant. This pins down exactly when frame_freed and slot_clr fire, and that a frame emptied by FREE_LANE stays out of the pool. A duplicate ID is allocated, an unknown ID is freed, and a preload is issued together with a command. Lookups made afterwards show that these rejected or ignored requests left the tag table untouched.

// File: rtl/frame_lane_alloc.sv
module frame_lane_alloc #(
  parameter int NF  = 8,
  parameter int NL  = 4,
  parameter int IDW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [IDW-1:0]         cmd_id,
  input  logic [IDW-1:0]         cmd_parent,
  output logic                   rsp_reject,
  output logic [$clog2(NF)-1:0]  rsp_frame,
  output logic [$clog2(NL)-1:0]  rsp_lane,
  output logic                   rsp_frame_freed,
  output logic                   lane_clr,
  output logic                   slot_clr,
  input  logic [IDW-1:0]         lk_id,
  output logic                   lk_miss,
  output logic [$clog2(NF)-1:0]  lk_frame,
  output logic [$clog2(NL)-1:0]  lk_lane,
  input  logic                   cfg_we,
  input  logic [$clog2(NF)-1:0]  cfg_frame,
  input  logic [$clog2(NL)-1:0]  cfg_lane,
  input  logic [IDW-1:0]         cfg_id
);
  localparam int NE = NF * NL;
  localparam int FW = $clog2(NF);
  localparam int LW = $clog2(NL);
  localparam int SW = $clog2(NE);
  localparam logic [1:0] OP_ALLOC = 2'd0, OP_FREE = 2'd1, OP_SHARE = 2'd2, OP_FLANE = 2'd3;

  logic [NF-1:0]  frame_used;
  logic [NE-1:0]  lane_busy;
  logic [IDW-1:0] ent_id [NE];

  logic [NF-1:0]  nx_used;
  logic [NE-1:0]  nx_busy;
  logic           wr;
  logic [SW-1:0]  widx;
  logic [IDW-1:0] wid;

  function automatic logic [SW:0] find(input logic [IDW-1:0] key);
    logic [SW:0] r = '0;
    for (int i = NE - 1; i >= 0; i--)
      if (lane_busy[i] && ent_id[i] == key) r = {1'b1, SW'(i)};
    return r;
  endfunction

  logic [SW:0] self_r, par_r, lk_r;
  assign self_r = find(cmd_id);
  assign par_r  = find(cmd_parent);
  assign lk_r   = find(lk_id);

  logic [FW-1:0] self_f, par_f;
  logic [LW-1:0] self_l;
  assign self_f = FW'(self_r[SW-1:0] / NL);
  assign self_l = LW'(self_r[SW-1:0] % NL);
  assign par_f  = FW'(par_r[SW-1:0] / NL);

  assign lk_miss  = !lk_r[SW];
  assign lk_frame = FW'(lk_r[SW-1:0] / NL);
  assign lk_lane  = LW'(lk_r[SW-1:0] % NL);

  logic          pool_ok, lane_ok;
  logic [FW-1:0] pool_f;
  logic [LW-1:0] free_l;
  always_comb begin
    pool_ok = 1'b0;
    pool_f  = '0;
    for (int f = NF - 1; f >= 0; f--)
      if (!frame_used[f]) begin pool_ok = 1'b1; pool_f = FW'(f); end
    lane_ok = 1'b0;
    free_l  = '0;
    for (int l = NL - 1; l >= 0; l--)
      if (!lane_busy[int'(par_f) * NL + l]) begin lane_ok = 1'b1; free_l = LW'(l); end
  end

  always_comb begin
    nx_used = frame_used;
    nx_busy = lane_busy;
    wr = 1'b0;
    widx = '0;
    wid = cmd_id;
    rsp_reject = 1'b0;
    rsp_frame = '0;
    rsp_lane = '0;
    rsp_frame_freed = 1'b0;
    lane_clr = 1'b0;
    if (cmd_valid) begin
      rsp_reject = 1'b1;
      case (cmd_op)
        OP_ALLOC:
          if (pool_ok && !self_r[SW]) begin
            rsp_reject = 1'b0;
            rsp_frame = pool_f;
            nx_used[pool_f] = 1'b1;
            nx_busy[int'(pool_f) * NL] = 1'b1;
            wr = 1'b1;
            widx = SW'(int'(pool_f) * NL);
          end
        OP_SHARE:
          if (par_r[SW] && lane_ok && !self_r[SW]) begin
            rsp_reject = 1'b0;
            rsp_frame = par_f;
            rsp_lane = free_l;
            nx_busy[int'(par_f) * NL + int'(free_l)] = 1'b1;
            wr = 1'b1;
            widx = SW'(int'(par_f) * NL + int'(free_l));
          end
        default:
          if (self_r[SW]) begin
            rsp_reject = 1'b0;
            rsp_frame = self_f;
            rsp_lane = self_l;
            lane_clr = 1'b1;
            nx_busy[self_r[SW-1:0]] = 1'b0;
            if (cmd_op == OP_FREE && (lane_busy[int'(self_f) * NL +: NL] & ~(NL'(1) << self_l)) == '0) begin
              rsp_frame_freed = 1'b1;
              nx_used[self_f] = 1'b0;
            end
          end
      endcase
    end else if (cfg_we) begin
      nx_busy[int'(cfg_frame) * NL + int'(cfg_lane)] = 1'b1;
      nx_used[cfg_frame] = 1'b1;
      wr = 1'b1;
      widx = SW'(int'(cfg_frame) * NL + int'(cfg_lane));
      wid = cfg_id;
    end
  end

  assign slot_clr = rsp_frame_freed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_used <= '0;
      lane_busy  <= '0;
    end else begin
      frame_used <= nx_used;
      lane_busy  <= nx_busy;
    end
  end

  always_ff @(posedge clk)
    if (wr) ent_id[widx] <= wid;

  assert_alloc_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_ALLOC && !rsp_reject
      |=> frame_used[$past(rsp_frame)] && lane_busy[int'($past(rsp_frame)) * NL +: NL] == NL'(1));

  assert_reject_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && rsp_reject |=> $stable(lane_busy) && $stable(frame_used));

  assert_flane_keeps_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_FLANE |=> !$past(rsp_frame_freed) && $stable(frame_used));

  assert_freed_returns_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_frame_freed |=> !frame_used[$past(rsp_frame)]);

  assert_lane_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lane_clr |=> !lane_busy[int'($past(rsp_frame)) * NL + int'($past(rsp_lane))]);

  for (genvar g = 0; g < NF; g++) begin : g_inv
    assert_idle_frame_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_used[g] |-> lane_busy[g * NL +: NL] == '0);
  end
endmodule

// File: tb/sim_frame_lane_alloc.sv
module sim_frame_lane_alloc;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_id = 0, cmd_parent = 0, lk_id = 0, cfg_id = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_frame = 0;
  logic [1:0] cfg_lane = 0;
  logic rsp_reject, rsp_frame_freed, lane_clr, slot_clr, lk_miss;
  logic [2:0] rsp_frame, lk_frame;
  logic [1:0] rsp_lane, lk_lane;
  int checks = 0, failures = 0;

  localparam logic [1:0] ALLOC = 0, FREE = 1, SHARE = 2, FLANE = 3;

  always #4 clk = ~clk;

  frame_lane_alloc u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int id, input int par, input bit erej,
                     input int ef, input int el, input bit efreed, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_id = 8'(id); cmd_parent = 8'(par);
    #2;
    chk(rsp_reject == erej, {tag, " reject"}, rsp_reject, erej);
    if (!erej) begin
      chk(rsp_frame == 3'(ef), {tag, " frame"}, rsp_frame, ef);
      chk(rsp_lane == 2'(el), {tag, " lane"}, rsp_lane, el);
      chk(rsp_frame_freed == efreed, {tag, " freed"}, rsp_frame_freed, efreed);
      chk(slot_clr == efreed, {tag, " slot_clr"}, slot_clr, efreed);
      chk(lane_clr == (op == FREE || op == FLANE), {tag, " lane_clr"}, lane_clr, op == FREE || op == FLANE);
    end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic look(input int id, input bit emiss, input int ef, input int el, input string tag);
    lk_id = 8'(id);
    #1;
    chk(lk_miss == emiss, {tag, " miss"}, lk_miss, emiss);
    if (!emiss) begin
      chk(lk_frame == 3'(ef), {tag, " lk_frame"}, lk_frame, ef);
      chk(lk_lane == 2'(el), {tag, " lk_lane"}, lk_lane, el);
    end
  endtask

  task automatic t_reset();
    look(5, 1, 0, 0, "R1 empty lookup");
    cmd(ALLOC, 10, 0, 0, 0, 0, 0, "R1 first alloc");
    look(10, 0, 0, 0, "R12 visible next cycle");
  endtask

  task automatic t_share();
    cmd(ALLOC, 11, 0, 0, 1, 0, 0, "R2 second alloc");
    cmd(ALLOC, 10, 0, 1, 0, 0, 0, "R3 duplicate id");
    cmd(SHARE, 20, 10, 0, 0, 1, 0, "R4 share lane1");
    cmd(SHARE, 21, 10, 0, 0, 2, 0, "R4 share lane2");
    cmd(SHARE, 22, 20, 0, 0, 3, 0, "R4 share via child");
    cmd(SHARE, 23, 10, 1, 0, 0, 0, "R5 frame full");
    cmd(SHARE, 24, 99, 1, 0, 0, 0, "R5 parent missing");
    cmd(SHARE, 11, 10, 1, 0, 0, 0, "R5 id bound");
    look(22, 0, 0, 3, "R10 hit");
    look(23, 1, 0, 0, "R5 rejected unbound");
  endtask

  task automatic t_free();
    cmd(FLANE, 21, 0, 0, 0, 2, 0, "R8 free lane");
    cmd(SHARE, 25, 11, 0, 1, 1, 0, "R4 share frame1");
    cmd(SHARE, 26, 10, 0, 0, 2, 0, "R4 lowest reuse");
    cmd(FREE, 10, 0, 0, 0, 0, 0, "R6 free shared");
    cmd(FREE, 20, 0, 0, 0, 1, 0, "R6 free shared");
    cmd(FREE, 22, 0, 0, 0, 3, 0, "R6 free shared");
    cmd(FREE, 26, 0, 0, 0, 2, 1, "R7 free last");
    look(26, 1, 0, 0, "R7 gone");
    cmd(FREE, 99, 0, 1, 0, 0, 0, "R9 unknown free");
    cmd(FLANE, 98, 0, 1, 0, 0, 0, "R9 unknown free lane");
    cmd(FLANE, 25, 0, 0, 1, 1, 0, "R8 flane");
    cmd(FLANE, 11, 0, 0, 1, 0, 0, "R8 flane last");
    cmd(ALLOC, 30, 0, 0, 0, 0, 0, "R7 reuse freed frame");
    cmd(ALLOC, 31, 0, 0, 2, 0, 0, "R8 frame1 skipped");
  endtask

  task automatic t_exhaust();
    for (int i = 0; i < 5; i++) cmd(ALLOC, 32 + i, 0, 0, 3 + i, 0, 0, "R2 fill pool");
    cmd(ALLOC, 38, 0, 1, 0, 0, 0, "R3 pool empty");
    look(38, 1, 0, 0, "R3 no binding");
    look(36, 0, 7, 0, "R3 state kept");
  endtask

  task automatic t_cfg();
    cmd(FREE, 36, 0, 0, 7, 0, 1, "R7 free frame7");
    @(negedge clk);
    cfg_we = 1; cfg_frame = 7; cfg_lane = 2; cfg_id = 50;
    @(negedge clk);
    cfg_we = 0;
    look(50, 0, 7, 2, "R11 preload");
    cmd(SHARE, 51, 50, 0, 7, 0, 0, "R11 share preload");
    @(negedge clk);
    cfg_we = 1; cfg_frame = 1; cfg_lane = 3; cfg_id = 60;
    cmd_valid = 1; cmd_op = ALLOC; cmd_id = 61;
    #2;
    chk(rsp_reject == 1, "R11 busy cmd reject", rsp_reject, 1);
    @(negedge clk);
    cmd_valid = 0; cfg_we = 0;
    look(60, 1, 0, 0, "R11 cfg ignored");
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_share();
    t_free();
    t_exhaust();
    t_cfg();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule